// File: doc/BRIEF.md
# MSI Directory Coherence Controller

This block sits beside a shared last-level cache. It keeps the private caches of several cores coherent under Modified/Shared/Invalid permissions. For every block it holds a permission state, a holder vector with one bit per core, a busy lock and the shared copy of the data. Cores send load misses, store misses, invalidation acknowledgements and unblock notices on their own input channel. The directory answers each core on that core's own output channel.

The protocol is blocking and three-hop. A load miss to a block that another core has Modified is forwarded to that owner, together with the requester's index. The owner returns the data straight to the requester. The requester then sends an unblock notice that carries the data, and the directory writes that data into its shared copy. A store miss to a block with sharers invalidates every other sharer. The directory counts the acknowledgements itself and sends the exclusive grant only after the last one has arrived. After each load or store miss is accepted, its block stays locked until the requester unblocks it.

All channels use valid/ready. On an input, a core holds valid and its fields steady until it sees ready high at a rising edge. Ready may depend on valid, and at most one input is accepted per cycle. On an output, the directory holds valid and the fields until the core raises ready. A core that holds ready low stalls every new miss request in the system.

Top module: `msi_dir_ctrl`

## Requirements
- R1: After reset every block is Invalid with no holders, its shared copy is zero, and no output is valid.
- R2: A load miss (input kind 0) to an Invalid or Shared block returns a shared grant (output kind 0) to the requester. The grant carries the shared copy, and the requester is added as a holder.
- R3: A store miss (input kind 1) to an Invalid block returns an exclusive grant (output kind 1) at once, carrying the shared copy. The requester becomes the sole owner.
- R4: A store miss to a Shared block sends an invalidation (output kind 4) to every holder except the requester. The exclusive grant goes to the requester only after one acknowledgement (input kind 3) has arrived from each of them.
- R5: A load miss to a Modified block sends a forward-load (output kind 2) to the owner, with the peer field set to the requester. The unblock (input kind 2) that follows writes its data into the shared copy, and both cores become Shared holders.
- R6: A store miss to a Modified block sends a forward-store (output kind 3) to the owner, with the peer field set to the requester. The requester becomes the new owner.
- R7: Once a load or store miss is accepted, its block stays locked until an unblock arrives. Further misses to that block keep ready low, while misses to other blocks are still served.
- R8: In any cycle, acknowledgements and unblocks win over miss requests. Within a class, the lowest core index wins, and only one input is granted.
- R9: No miss request is accepted while acknowledgements are still outstanding or while any output slot is full.
- R10: An output message stays valid with unchanged fields until its ready is seen high.
- R11: A Modified block always has exactly one holder, so a single writer never coexists with readers in the directory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NCORE | Per-core input message valid |
| in_ready | output | NCORE | Per-core input accepted this cycle |
| in_kind | input | 2*NCORE | Per-core kind: 0 load, 1 store, 2 unblock, 3 ack |
| in_addr | input | AW*NCORE | Per-core block index |
| in_data | input | DW*NCORE | Per-core data (used by unblock) |
| out_valid | output | NCORE | Per-core output message valid |
| out_ready | input | NCORE | Per-core output consumed |
| out_kind | output | 3*NCORE | 0 grant S, 1 grant M, 2 fwd load, 3 fwd store, 4 invalidate |
| out_addr | output | AW*NCORE | Block index of the message |
| out_data | output | DW*NCORE | Shared copy data for grants |
| out_peer | output | CW*NCORE | Requester index for forwards and invalidations |

## Verification
Unblocks and acknowledgements can arrive in the same cycle as a new miss request from another core, and the two compete for the single input grant. The bench provokes this by raising one core's unblock for a locked block and another core's load to a different block on the same clock edge. It then checks that only the unblock sees ready that cycle. In the following cycles it checks that the freed block's stalled request is served first, by lowest index, and that the other load is held off while the resulting grant still occupies an output slot.

// File: rtl/msi_dir_pkg.sv
package msi_dir_pkg;
  localparam logic [1:0] ST_I = 2'd0;
  localparam logic [1:0] ST_S = 2'd1;
  localparam logic [1:0] ST_M = 2'd2;

  localparam logic [1:0] IN_LOAD    = 2'd0;
  localparam logic [1:0] IN_STORE   = 2'd1;
  localparam logic [1:0] IN_UNBLOCK = 2'd2;
  localparam logic [1:0] IN_INVACK  = 2'd3;

  localparam logic [2:0] OUT_GRANT_S   = 3'd0;
  localparam logic [2:0] OUT_GRANT_M   = 3'd1;
  localparam logic [2:0] OUT_FWD_LOAD  = 3'd2;
  localparam logic [2:0] OUT_FWD_STORE = 3'd3;
  localparam logic [2:0] OUT_INVAL     = 3'd4;
endpackage

// File: rtl/msi_dir_arb.sv
module msi_dir_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rsp_valid,
  input  logic [N-1:0] req_ok,
  output logic [N-1:0] grant
);
  logic hit;

  always_comb begin
    grant = '0;
    hit   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!hit && rsp_valid[i]) begin
        grant[i] = 1'b1;
        hit      = 1'b1;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (!hit && req_ok[i]) begin
        grant[i] = 1'b1;
        hit      = 1'b1;
      end
    end
  end

  assert_single_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)) else $error("more than one input granted");

  assert_rsp_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid) |-> ((grant & ~rsp_valid) == '0)) else $error("request beat a response");
endmodule

// File: rtl/msi_dir_outq.sv
module msi_dir_outq #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [2:0]    ld_kind,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [CW-1:0] ld_peer,
  output logic          o_valid,
  input  logic          o_ready,
  output logic [2:0]    o_kind,
  output logic [AW-1:0] o_addr,
  output logic [DW-1:0] o_data,
  output logic [CW-1:0] o_peer
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_kind  <= '0;
      o_addr  <= '0;
      o_data  <= '0;
      o_peer  <= '0;
    end else if (load) begin
      o_valid <= 1'b1;
      o_kind  <= ld_kind;
      o_addr  <= ld_addr;
      o_data  <= ld_data;
      o_peer  <= ld_peer;
    end else if (o_ready) begin
      o_valid <= 1'b0;
    end
  end

  assert_hold_msg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_kind) && $stable(o_addr) && $stable(o_data)))
    else $error("output message changed while stalled");

  assert_no_clobber_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !o_valid) else $error("output slot overwritten");
endmodule

// File: rtl/msi_dir_ctrl.sv
module msi_dir_ctrl
  import msi_dir_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NBLK  = 16,
  parameter int DW    = 16,
  localparam int AW   = $clog2(NBLK),
  localparam int CW   = $clog2(NCORE)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCORE-1:0]      in_valid,
  output logic [NCORE-1:0]      in_ready,
  input  logic [2*NCORE-1:0]    in_kind,
  input  logic [AW*NCORE-1:0]   in_addr,
  input  logic [DW*NCORE-1:0]   in_data,
  output logic [NCORE-1:0]      out_valid,
  input  logic [NCORE-1:0]      out_ready,
  output logic [3*NCORE-1:0]    out_kind,
  output logic [AW*NCORE-1:0]   out_addr,
  output logic [DW*NCORE-1:0]   out_data,
  output logic [CW*NCORE-1:0]   out_peer
);
  localparam int CNTW = $clog2(NCORE + 1);

  // directory array
  logic [1:0]       st_q   [NBLK];
  logic [NCORE-1:0] hold_q [NBLK];
  logic [DW-1:0]    mem_q  [NBLK];
  logic [NBLK-1:0]  busy_q;
  logic [NBLK-1:0]  wbk_q;

  // acknowledgement collector
  logic [CNTW-1:0]  coll_cnt_q;
  logic [CW-1:0]    coll_core_q;
  logic [AW-1:0]    coll_addr_q;
  logic             coll_on;
  assign coll_on = (coll_cnt_q != '0);

  logic [1:0]       kind_a [NCORE];
  logic [AW-1:0]    addr_a [NCORE];
  logic [DW-1:0]    data_a [NCORE];
  logic [NCORE-1:0] rsp_v, req_ok, grant;

  for (genvar g = 0; g < NCORE; g++) begin : g_unpack
    assign kind_a[g] = in_kind[2*g +: 2];
    assign addr_a[g] = in_addr[AW*g +: AW];
    assign data_a[g] = in_data[DW*g +: DW];
    assign rsp_v[g]  = in_valid[g] & kind_a[g][1];
    assign req_ok[g] = in_valid[g] & ~kind_a[g][1] & ~busy_q[addr_a[g]] & ~coll_on & ~(|out_valid);
  end

  msi_dir_arb #(.N(NCORE)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_valid (rsp_v),
    .req_ok    (req_ok),
    .grant     (grant)
  );
  assign in_ready = grant;

  // selected message
  logic          fire;
  logic [CW-1:0] sel_core;
  always_comb begin
    fire     = |grant;
    sel_core = '0;
    for (int i = 0; i < NCORE; i++) if (grant[i]) sel_core = CW'(i);
  end

  logic [1:0]       sel_kind;
  logic [AW-1:0]    sel_addr;
  logic [DW-1:0]    sel_data;
  assign sel_kind = kind_a[sel_core];
  assign sel_addr = addr_a[sel_core];
  assign sel_data = data_a[sel_core];

  logic [1:0]       cur_st;
  logic [NCORE-1:0] cur_hold, req_bit, inv_mask;
  logic [CW-1:0]    owner;
  assign cur_st   = st_q[sel_addr];
  assign cur_hold = hold_q[sel_addr];
  assign req_bit  = NCORE'(1) << sel_core;
  assign inv_mask = (cur_st == ST_M) ? '0 : (cur_hold & ~req_bit);

  always_comb begin
    owner = '0;
    for (int i = 0; i < NCORE; i++) if (cur_hold[i]) owner = CW'(i);
  end

  logic is_ld, is_st, is_unb, is_ack, last_ack;
  assign is_ld    = fire & (sel_kind == IN_LOAD);
  assign is_st    = fire & (sel_kind == IN_STORE);
  assign is_unb   = fire & (sel_kind == IN_UNBLOCK);
  assign is_ack   = fire & (sel_kind == IN_INVACK);
  assign last_ack = is_ack & (coll_cnt_q == CNTW'(1));

  // outgoing message decode
  logic [NCORE-1:0] ld_en;
  logic [2:0]       ld_kind [NCORE];
  logic [AW-1:0]    msg_addr;
  logic [DW-1:0]    msg_data;

  always_comb begin
    ld_en = '0;
    for (int i = 0; i < NCORE; i++) ld_kind[i] = OUT_GRANT_S;
    msg_addr = sel_addr;
    msg_data = mem_q[sel_addr];
    if (last_ack) begin
      ld_en[coll_core_q]   = 1'b1;
      ld_kind[coll_core_q] = OUT_GRANT_M;
      msg_addr             = coll_addr_q;
      msg_data             = mem_q[coll_addr_q];
    end else if (is_ld) begin
      if (cur_st == ST_M) begin
        ld_en[owner]   = 1'b1;
        ld_kind[owner] = OUT_FWD_LOAD;
      end else begin
        ld_en[sel_core]   = 1'b1;
        ld_kind[sel_core] = OUT_GRANT_S;
      end
    end else if (is_st) begin
      if (cur_st == ST_M) begin
        ld_en[owner]   = 1'b1;
        ld_kind[owner] = OUT_FWD_STORE;
      end else begin
        for (int j = 0; j < NCORE; j++) begin
          if (inv_mask[j]) begin
            ld_en[j]   = 1'b1;
            ld_kind[j] = OUT_INVAL;
          end
        end
        if (inv_mask == '0) begin
          ld_en[sel_core]   = 1'b1;
          ld_kind[sel_core] = OUT_GRANT_M;
        end
      end
    end
  end

  for (genvar g = 0; g < NCORE; g++) begin : g_outq
    msi_dir_outq #(.AW(AW), .DW(DW), .CW(CW)) u_oq (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ld_en[g]),
      .ld_kind (ld_kind[g]),
      .ld_addr (msg_addr),
      .ld_data (msg_data),
      .ld_peer (sel_core),
      .o_valid (out_valid[g]),
      .o_ready (out_ready[g]),
      .o_kind  (out_kind[3*g +: 3]),
      .o_addr  (out_addr[AW*g +: AW]),
      .o_data  (out_data[DW*g +: DW]),
      .o_peer  (out_peer[CW*g +: CW])
    );
  end

  // directory state update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        st_q[b]   <= ST_I;
        hold_q[b] <= '0;
        mem_q[b]  <= '0;
      end
      busy_q      <= '0;
      wbk_q       <= '0;
      coll_cnt_q  <= '0;
      coll_core_q <= '0;
      coll_addr_q <= '0;
    end else begin
      if (is_ld) begin
        busy_q[sel_addr] <= 1'b1;
        st_q[sel_addr]   <= ST_S;
        hold_q[sel_addr] <= cur_hold | req_bit;
        if (cur_st == ST_M) wbk_q[sel_addr] <= 1'b1;
      end
      if (is_st) begin
        busy_q[sel_addr] <= 1'b1;
        st_q[sel_addr]   <= ST_M;
        hold_q[sel_addr] <= req_bit;
        if (inv_mask != '0) begin
          coll_cnt_q  <= CNTW'($countones(inv_mask));
          coll_core_q <= sel_core;
          coll_addr_q <= sel_addr;
        end
      end
      if (is_unb) begin
        busy_q[sel_addr] <= 1'b0;
        if (wbk_q[sel_addr]) begin
          mem_q[sel_addr] <= sel_data;
          wbk_q[sel_addr] <= 1'b0;
        end
      end
      if (is_ack && coll_on) coll_cnt_q <= coll_cnt_q - CNTW'(1);
    end
  end

  for (genvar g = 0; g < NBLK; g++) begin : g_inv
    assert_one_writer_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == ST_M) |-> ($countones(hold_q[g]) == 1)) else $error("modified block without single owner");
    assert_invalid_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == ST_I) |-> (hold_q[g] == '0)) else $error("invalid block with holders");
  end

  assert_lock_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ld || is_st) |=> busy_q[$past(sel_addr)]) else $error("accepted miss left block unlocked");

  assert_quiet_collect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    coll_on |-> !(is_ld || is_st)) else $error("miss accepted while acks outstanding");

  assert_grant_after_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_ack |=> out_valid[$past(coll_core_q)]) else $error("no exclusive grant after last ack");
endmodule

// File: tb/msi_dir_ctrl_tb.sv
`timescale 1ns/1ps
module msi_dir_ctrl_tb;
  localparam int NC = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int CW = 2;
  localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_UNB = 2'd2, K_ACK = 2'd3;
  localparam int GS = 0, GM = 1, FL = 2, FS = 3, INV = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rst_n;
  logic [NC-1:0]       in_valid, in_ready, out_valid, out_ready;
  logic [2*NC-1:0]     in_kind;
  logic [AW*NC-1:0]    in_addr, out_addr;
  logic [DW*NC-1:0]    in_data, out_data;
  logic [3*NC-1:0]     out_kind;
  logic [CW*NC-1:0]    out_peer;

  msi_dir_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_addr(out_addr), .out_data(out_data), .out_peer(out_peer)
  );

  int total = 0;
  int bad   = 0;

  logic [2:0]    ck [NC][64];
  logic [AW-1:0] ca [NC][64];
  logic [DW-1:0] cd [NC][64];
  logic [CW-1:0] cp [NC][64];
  int wr [NC] = '{default: 0};
  int rd [NC] = '{default: 0};

  always @(negedge clk) begin
    #1;
    for (int c = 0; c < NC; c++) begin
      if (out_valid[c] && out_ready[c] && wr[c] < 64) begin
        ck[c][wr[c]] = out_kind[3*c +: 3];
        ca[c][wr[c]] = out_addr[AW*c +: AW];
        cd[c][wr[c]] = out_data[DW*c +: DW];
        cp[c][wr[c]] = out_peer[CW*c +: CW];
        wr[c]++;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic post(int c, logic [1:0] k, int a, int d);
    in_valid[c]             = 1'b1;
    in_kind[2*c +: 2]       = k;
    in_addr[AW*c +: AW]     = AW'(a);
    in_data[DW*c +: DW]     = DW'(d);
  endtask

  task automatic wait_taken(int c, string req);
    int n = 0;
    #2;
    while (!in_ready[c] && n < 100) begin
      @(negedge clk); #2; n++;
    end
    chk(in_ready[c] == 1'b1, req, "input accepted", int'(in_ready[c]), 1);
    @(negedge clk);
    in_valid[c] = 1'b0;
  endtask

  task automatic send(int c, logic [1:0] k, int a, int d, string req);
    @(negedge clk);
    post(c, k, a, d);
    wait_taken(c, req);
  endtask

  task automatic expect_msg(int c, int k, int a, int d, int p, string req);
    int n = 0;
    while (rd[c] == wr[c] && n < 30) begin
      @(negedge clk); n++;
    end
    if (rd[c] == wr[c]) begin
      chk(1'b0, req, "message missing, kind", -1, k);
    end else begin
      chk(int'(ck[c][rd[c]]) == k, req, "message kind", int'(ck[c][rd[c]]), k);
      chk(int'(ca[c][rd[c]]) == a, req, "message addr", int'(ca[c][rd[c]]), a);
      if (d >= 0) chk(int'(cd[c][rd[c]]) == d, req, "message data", int'(cd[c][rd[c]]), d);
      if (p >= 0) chk(int'(cp[c][rd[c]]) == p, req, "message peer", int'(cp[c][rd[c]]), p);
      rd[c]++;
    end
  endtask

  task automatic expect_none(int c, int cyc, string req);
    repeat (cyc) @(negedge clk);
    chk(rd[c] == wr[c], req, "unexpected message count", wr[c] - rd[c], 0);
  endtask

  task automatic stall_check(int c, int cyc, string req);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk); #2;
      chk(in_ready[c] == 1'b0, req, "request stalled", int'(in_ready[c]), 0);
    end
  endtask

  task automatic t_reset;
    #2;
    chk(out_valid == '0, "R1", "outputs idle after reset", int'(out_valid), 0);
    chk(in_ready == '0, "R1", "no input granted", int'(in_ready), 0);
  endtask

  task automatic t_shared_reads;
    send(0, K_LD, 3, 0, "R2");
    expect_msg(0, GS, 3, 0, -1, "R1");
    send(0, K_UNB, 3, 0, "R2");
    send(1, K_LD, 3, 0, "R2");
    expect_msg(1, GS, 3, 0, -1, "R2");
    send(1, K_UNB, 3, 0, "R2");
  endtask

  task automatic t_invalidate;
    send(2, K_ST, 3, 0, "R4");
    expect_msg(0, INV, 3, -1, 2, "R4");
    expect_msg(1, INV, 3, -1, 2, "R4");
    @(negedge clk);
    post(3, K_LD, 12, 0);
    stall_check(3, 3, "R9");
    chk(rd[2] == wr[2], "R4", "grant before acks", wr[2] - rd[2], 0);
    send(0, K_ACK, 3, 0, "R4");
    expect_none(2, 3, "R4");
    send(1, K_ACK, 3, 0, "R4");
    expect_msg(2, GM, 3, 0, -1, "R4");
    wait_taken(3, "R9");
    expect_msg(3, GS, 12, 0, -1, "R9");
    send(2, K_UNB, 3, 0, "R4");
    send(3, K_UNB, 12, 0, "R9");
  endtask

  task automatic t_forward_load;
    send(3, K_LD, 3, 0, "R5");
    expect_msg(2, FL, 3, -1, 3, "R5");
    expect_none(3, 2, "R5");
    send(3, K_UNB, 3, 16'h1234, "R5");
    send(0, K_LD, 3, 0, "R5");
    expect_msg(0, GS, 3, 16'h1234, -1, "R5");
    send(0, K_UNB, 3, 0, "R5");
    send(1, K_ST, 3, 0, "R5");
    expect_msg(0, INV, 3, -1, 1, "R5");
    expect_msg(2, INV, 3, -1, 1, "R5");
    expect_msg(3, INV, 3, -1, 1, "R5");
    send(0, K_ACK, 3, 0, "R4");
    send(2, K_ACK, 3, 0, "R4");
    send(3, K_ACK, 3, 0, "R4");
    expect_msg(1, GM, 3, 16'h1234, -1, "R4");
    send(1, K_UNB, 3, 0, "R4");
  endtask

  task automatic t_forward_store;
    send(0, K_ST, 3, 0, "R6");
    expect_msg(1, FS, 3, -1, 0, "R6");
    send(0, K_UNB, 3, 0, "R6");
    send(2, K_LD, 3, 0, "R11");
    expect_msg(0, FL, 3, -1, 2, "R11");
    expect_none(1, 2, "R11");
    send(2, K_UNB, 3, 16'h0bee, "R5");
    send(3, K_LD, 3, 0, "R5");
    expect_msg(3, GS, 3, 16'h0bee, -1, "R5");
    send(3, K_UNB, 3, 0, "R5");
  endtask

  task automatic t_busy_and_priority;
    send(3, K_LD, 5, 0, "R7");
    expect_msg(3, GS, 5, 0, -1, "R2");
    @(negedge clk);
    post(0, K_LD, 5, 0);
    stall_check(0, 4, "R7");
    send(2, K_LD, 6, 0, "R7");
    expect_msg(2, GS, 6, 0, -1, "R7");
    send(2, K_UNB, 6, 0, "R7");
    @(negedge clk);
    post(1, K_LD, 8, 0);
    post(3, K_UNB, 5, 0);
    #2;
    chk(in_ready[3] == 1'b1 && in_ready[1] == 1'b0, "R8", "response wins same cycle",
        int'(in_ready), 8);
    @(negedge clk);
    in_valid[3] = 1'b0;
    #2;
    chk(in_ready[0] == 1'b1 && in_ready[1] == 1'b0, "R8", "lowest index wins after unlock",
        int'(in_ready), 1);
    @(negedge clk);
    in_valid[0] = 1'b0;
    wait_taken(1, "R9");
    expect_msg(0, GS, 5, 0, -1, "R7");
    expect_msg(1, GS, 8, 0, -1, "R8");
    send(0, K_UNB, 5, 0, "R7");
    send(1, K_UNB, 8, 0, "R8");
  endtask

  task automatic t_exclusive_and_upgrade;
    send(1, K_ST, 9, 0, "R3");
    expect_msg(1, GM, 9, 0, -1, "R3");
    send(1, K_UNB, 9, 0, "R3");
    send(0, K_LD, 7, 0, "R4");
    expect_msg(0, GS, 7, 0, -1, "R2");
    send(0, K_UNB, 7, 0, "R4");
    send(1, K_LD, 7, 0, "R4");
    expect_msg(1, GS, 7, 0, -1, "R2");
    send(1, K_UNB, 7, 0, "R4");
    send(0, K_ST, 7, 0, "R4");
    expect_msg(1, INV, 7, -1, 0, "R4");
    expect_none(0, 2, "R4");
    send(1, K_ACK, 7, 0, "R4");
    expect_msg(0, GM, 7, 0, -1, "R4");
    send(0, K_UNB, 7, 0, "R4");
    send(2, K_LD, 9, 0, "R11");
    expect_msg(1, FL, 9, -1, 2, "R11");
    send(2, K_UNB, 9, 16'h55aa, "R5");
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready[2] = 1'b0;
    send(2, K_LD, 10, 0, "R10");
    @(negedge clk);
    post(1, K_LD, 11, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #2;
      chk(out_valid[2] == 1'b1 && out_kind[6 +: 3] == 3'd0 && out_addr[8 +: 4] == 4'd10,
          "R10", "held message", int'(out_valid[2]), 1);
      chk(in_ready[1] == 1'b0, "R9", "request held while slot full", int'(in_ready[1]), 0);
    end
    @(negedge clk);
    out_ready[2] = 1'b1;
    expect_msg(2, GS, 10, 0, -1, "R10");
    wait_taken(1, "R9");
    expect_msg(1, GS, 11, 0, -1, "R9");
    expect_none(2, 3, "R10");
    send(2, K_UNB, 10, 0, "R10");
    send(1, K_UNB, 11, 0, "R9");
  endtask

  initial begin
    in_valid  = '0;
    in_kind   = '0;
    in_addr   = '0;
    in_data   = '0;
    out_ready = '1;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_shared_reads;
    t_invalidate;
    t_forward_load;
    t_forward_store;
    t_busy_and_priority;
    t_exclusive_and_upgrade;
    t_backpressure;
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule